// File: doc/BRIEF.md
# Bus-Off Recovery Monitor

This block follows a serial-bus controller channel from the moment it drops into bus-off until it leaves that state. During bus-off it watches the sampled receive line on every bit strobe. It counts runs of a fixed number of back-to-back recessive bits (11 by default). Normal recovery is complete once a set number of such runs has been seen (128 by default). At that point the bus-off state ends and a sticky recovered flag is raised, which can drive an interrupt request.

Software and the recovery-mode setting can also end bus-off before the count completes. These exits are a channel-reset request, a forced-recovery command, standby at the start of bus-off, and a standby request when the mode allows it. None of these exits raises the recovered flag. A fresh bus-off entry pulse always restarts the count from zero. The block does no error counting and no frame decoding.

Encodings used throughout: `rx_bit` 1 = recessive, 0 = dominant. `rec_mode`: 00 = automatic recovery, 01 = standby on bus-off entry, 10 = standby when recovery completes, 11 = standby only on software request. `mode_req_code`: 00 = operate, 01 = channel reset, 10 = standby, 11 = no action.

Top module: `busoff_recovery_monitor`

## Requirements
- R1: After reset, `busoff`, `recovered`, `standby` and `irq` are all 0.
- R2: A `busoff_enter` pulse with `rec_mode` other than 01 sets `busoff` to 1 and `standby` to 0 on the next cycle.
- R3: During bus-off, each strobe with `rx_bit`=1 extends the current recessive run. A strobed dominant bit (`rx_bit`=0) restarts the run but keeps the number of completed runs. Cycles with `bit_strobe`=0 have no effect on either count.
- R4: A recessive run longer than 11 bits counts one completed run for each full 11 bits. For example, 22 recessive bits in a row count as two runs.
- R5: The strobe that completes the 128th run clears `busoff` and sets `recovered` on the next cycle. Until that strobe, `busoff` stays 1.
- R6: `recovered` stays 1 until a `flag_clear` pulse clears it.
- R7: `irq` is 1 exactly when `recovered` and `irq_en` are both 1.
- R8: A mode request with code 01 (channel reset) during bus-off clears `busoff` and `standby` on the next cycle and leaves `recovered` at 0.
- R9: A `force_recover` pulse during bus-off clears `busoff` on the next cycle and leaves `recovered` at 0.
- R10: With `rec_mode`=01, a `busoff_enter` pulse gives `standby`=1 and `busoff`=0 on the next cycle, and no recovered flag follows.
- R11: With `rec_mode`=11, a mode request with code 10 during bus-off gives `standby`=1 and `busoff`=0 and no flag. With `rec_mode`=00, the same request has no effect, and `busoff` stays 1.
- R12: With `rec_mode`=10, completing the 128th run sets both `recovered` and `standby`.
- R13: Outside bus-off, a mode request with code 00 or 01 clears `standby`.
- R14: A `busoff_enter` pulse in the middle of a recovery restarts both counts. After it, a further full 128 runs are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse marking a valid bus sample |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| busoff_enter | input | 1 | Pulse: channel has entered bus-off |
| rec_mode | input | 2 | Recovery-mode select |
| mode_req_valid | input | 1 | Pulse qualifying `mode_req_code` |
| mode_req_code | input | 2 | Requested channel mode |
| force_recover | input | 1 | Pulse: leave bus-off at once |
| flag_clear | input | 1 | Pulse: clear the recovered flag |
| irq_en | input | 1 | Interrupt enable |
| busoff | output | 1 | Channel is in bus-off |
| standby | output | 1 | Channel is in standby |
| recovered | output | 1 | Sticky normal-recovery flag |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven three ways. The first is an unbroken stream of recessive strobes, which checks the 11-bit boundary and the 128-run boundary. The second is runs broken by dominant bits, which shows whether a dominant restarts only the run and leaves the completed-run count alone. The third is strobes spread out with idle cycles on a dominant line, which shows whether non-strobed cycles are ignored. Each early exit is applied partway through a recovery, so an exit that raised the flag, or that failed to stop the count, shows up as a difference from the behavioural reference. A second entry pulse is applied mid-recovery; it must restart both counts, and a stale count would end bus-off too soon.

// File: rtl/bor_pkg.sv
package bor_pkg;

   typedef enum logic [1:0] {
      REC_AUTO         = 2'b00,
      REC_SBY_AT_ENTRY = 2'b01,
      REC_SBY_AT_END   = 2'b10,
      REC_SBY_ON_REQ   = 2'b11
   } rec_mode_e;

   typedef enum logic [1:0] {
      REQ_OPERATE = 2'b00,
      REQ_RESET   = 2'b01,
      REQ_STANDBY = 2'b10,
      REQ_NOP     = 2'b11
   } mode_req_e;

endpackage

// File: rtl/bor_run_counter.sv
module bor_run_counter #(
   parameter int RUN_LEN = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   input  logic recessive_i,
   output logic done_o
);
   localparam int RW = $clog2(RUN_LEN + 1);
   localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

   if (RUN_LEN < 2) begin : g_bad_len
      $error("bor_run_counter: RUN_LEN must be at least 2");
   end

   logic [RW-1:0] cnt_q;

   assign done_o = en_i & recessive_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (!recessive_i || done_o) cnt_q <= '0;
         else                        cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: run count never reaches the run length
   p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R3: a strobed dominant bit restarts the run
   p_dominant_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !recessive_i) |=> (cnt_q == '0));

endmodule

// File: rtl/bor_seq_counter.sv
module bor_seq_counter #(
   parameter int SEQ_TARGET = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);
   localparam int SW = $clog2(SEQ_TARGET + 1);
   localparam logic [SW-1:0] LAST = SW'(SEQ_TARGET - 1);

   if (SEQ_TARGET < 1) begin : g_bad_target
      $error("bor_seq_counter: SEQ_TARGET must be at least 1");
   end

   logic [SW-1:0] cnt_q;

   assign hit_o = inc_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (hit_o)   cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + 1'b1;
   end

   // R3: completed-run count holds when no run finishes
   p_seq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(cnt_q));

   // R5: count stays inside the target
   p_seq_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
   import bor_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      busoff_enter_i,
   input  rec_mode_e rec_mode_i,
   input  logic      req_valid_i,
   input  mode_req_e req_code_i,
   input  logic      force_i,
   input  logic      flag_clear_i,
   input  logic      target_hit_i,
   output logic      count_en_o,
   output logic      count_clr_o,
   output logic      busoff_o,
   output logic      standby_o,
   output logic      flag_o
);
   logic busoff_q, standby_q, flag_q;
   logic exit_reset, exit_force, exit_sby, early_exit, normal_done;

   always_comb begin
      exit_reset  = busoff_q & req_valid_i & (req_code_i == REQ_RESET);
      exit_force  = busoff_q & force_i & ~exit_reset;
      exit_sby    = busoff_q & req_valid_i & (req_code_i == REQ_STANDBY)
                    & (rec_mode_i == REC_SBY_ON_REQ);
      early_exit  = exit_reset | exit_force | exit_sby;
      count_en_o  = busoff_q & ~busoff_enter_i & ~early_exit;
      count_clr_o = busoff_enter_i | ~busoff_q | early_exit;
      normal_done = count_en_o & target_hit_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busoff_q  <= 1'b0;
         standby_q <= 1'b0;
      end else if (busoff_enter_i) begin
         busoff_q  <= (rec_mode_i != REC_SBY_AT_ENTRY);
         standby_q <= (rec_mode_i == REC_SBY_AT_ENTRY);
      end else if (busoff_q) begin
         if (early_exit) begin
            busoff_q  <= 1'b0;
            standby_q <= exit_sby;
         end else if (normal_done) begin
            busoff_q  <= 1'b0;
            standby_q <= (rec_mode_i == REC_SBY_AT_END);
         end
      end else if (req_valid_i &&
                   (req_code_i == REQ_OPERATE || req_code_i == REQ_RESET)) begin
         standby_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= 1'b0;
      else if (normal_done)  flag_q <= 1'b1;
      else if (flag_clear_i) flag_q <= 1'b0;
   end

   assign busoff_o  = busoff_q;
   assign standby_o = standby_q;
   assign flag_o    = flag_q;

   // R8: channel-reset request ends bus-off without a flag
   p_reset_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_q && req_valid_i && req_code_i == REQ_RESET && !busoff_enter_i)
      |=> (!busoff_q && !standby_q && !$rose(flag_q)));

   // R9: forced recovery ends bus-off without a flag
   p_force_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_q && force_i && !busoff_enter_i) |=> (!busoff_q && !$rose(flag_q)));

   // R10: standby right at entry
   p_entry_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_enter_i && rec_mode_i == REC_SBY_AT_ENTRY) |=> (standby_q && !busoff_q));

   // R6: flag is sticky until cleared
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clear_i) |=> flag_q);

   // R5: flag only rises out of bus-off
   p_flag_from_busoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> ($past(busoff_q) && !busoff_q));

   // R11: never in bus-off and standby together
   p_state_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(busoff_q && standby_q));

endmodule

// File: rtl/busoff_recovery_monitor.sv
module busoff_recovery_monitor
   import bor_pkg::*;
#(
   parameter int RUN_LEN    = 11,
   parameter int SEQ_TARGET = 128,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_strobe,
   input  logic       rx_bit,
   input  logic       busoff_enter,
   input  logic [1:0] rec_mode,
   input  logic       mode_req_valid,
   input  logic [1:0] mode_req_code,
   input  logic       force_recover,
   input  logic       flag_clear,
   input  logic       irq_en,
   output logic       busoff,
   output logic       standby,
   output logic       recovered,
   output logic       irq
);
   logic count_en, count_clr, run_done, target_hit;

   bor_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .busoff_enter_i (busoff_enter),
      .rec_mode_i     (rec_mode_e'(rec_mode)),
      .req_valid_i    (mode_req_valid),
      .req_code_i     (mode_req_e'(mode_req_code)),
      .force_i        (force_recover),
      .flag_clear_i   (flag_clear),
      .target_hit_i   (target_hit),
      .count_en_o     (count_en),
      .count_clr_o    (count_clr),
      .busoff_o       (busoff),
      .standby_o      (standby),
      .flag_o         (recovered)
   );

   bor_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (count_clr),
      .en_i        (count_en & bit_strobe),
      .recessive_i (rx_bit),
      .done_o      (run_done)
   );

   bor_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (count_clr),
      .inc_i (run_done),
      .hit_o (target_hit)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= recovered & irq_en;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = recovered & irq_en;
   end

   // R7: no request without the flag
   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (IRQ_REG ? $past(recovered) : recovered));

endmodule

// File: tb/test_busoff_recovery_monitor.sv
module test_busoff_recovery_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_strobe = 0, rx_bit = 0, busoff_enter = 0, mode_req_valid = 0;
   logic force_recover = 0, flag_clear = 0, irq_en = 0;
   logic [1:0] rec_mode = 2'b00, mode_req_code = 2'b11;
   logic busoff, standby, recovered, irq;

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit started = 0;

   // reference state
   int m_run = 0, m_seq = 0;
   bit m_bo = 0, m_sb = 0, m_fl = 0;

   always #10 clk = ~clk;

   busoff_recovery_monitor i_busoff_recovery_monitor (
      .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
      .busoff_enter(busoff_enter), .rec_mode(rec_mode),
      .mode_req_valid(mode_req_valid), .mode_req_code(mode_req_code),
      .force_recover(force_recover), .flag_clear(flag_clear), .irq_en(irq_en),
      .busoff(busoff), .standby(standby), .recovered(recovered), .irq(irq));

   // behavioural reference model
   always @(posedge clk) begin
      bit nb, ns, nf;
      if (!rst_n) begin
         m_run = 0; m_seq = 0; m_bo = 0; m_sb = 0; m_fl = 0;
      end else begin
         nb = m_bo; ns = m_sb; nf = m_fl;
         if (flag_clear) nf = 0;
         if (busoff_enter) begin
            m_run = 0; m_seq = 0;
            if (rec_mode == 2'b01) begin nb = 0; ns = 1; end
            else begin nb = 1; ns = 0; end
         end else if (m_bo) begin
            if (mode_req_valid && mode_req_code == 2'b01) begin nb = 0; ns = 0; end
            else if (force_recover) nb = 0;
            else if (mode_req_valid && mode_req_code == 2'b10 && rec_mode == 2'b11) begin
               nb = 0; ns = 1;
            end else if (bit_strobe) begin
               if (rx_bit) begin
                  m_run++;
                  if (m_run == 11) begin
                     m_run = 0; m_seq++;
                     if (m_seq == 128) begin
                        nb = 0; nf = 1;
                        if (rec_mode == 2'b10) ns = 1;
                     end
                  end
               end else m_run = 0;
            end
         end else if (mode_req_valid && (mode_req_code == 2'b00 || mode_req_code == 2'b01)) begin
            ns = 0;
         end
         if (!nb) begin m_run = 0; m_seq = 0; end
         m_bo = nb; m_sb = ns; m_fl = nf;
      end
      if (started) cyc++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (started && rst_n) begin
         chk(busoff == m_bo, "R5", "busoff", busoff, m_bo);
         chk(standby == m_sb, "R11", "standby", standby, m_sb);
         chk(recovered == m_fl, "R6", "recovered", recovered, m_fl);
         chk(irq == (m_fl & irq_en), "R7", "irq", irq, m_fl & irq_en);
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobes(input int n, input bit val, input bit gap);
      for (int i = 0; i < n; i++) begin
         bit_strobe = 1; rx_bit = val;
         @(negedge clk);
         bit_strobe = 0;
         if (gap) begin rx_bit = 0; @(negedge clk); end
      end
      rx_bit = 0;
   endtask

   task automatic enter(input logic [1:0] mode);
      rec_mode = mode; busoff_enter = 1;
      @(negedge clk);
      busoff_enter = 0;
   endtask

   task automatic request(input logic [1:0] code);
      mode_req_valid = 1; mode_req_code = code;
      @(negedge clk);
      mode_req_valid = 0; mode_req_code = 2'b11;
   endtask

   task automatic clear_flag();
      flag_clear = 1; @(negedge clk); flag_clear = 0;
   endtask

   initial begin
      started = 1;
      idle(3);
      rst_n = 1;
      idle(1);
      // R1
      chk(busoff == 0 && standby == 0 && recovered == 0 && irq == 0, "R1",
          "reset outputs", {busoff, standby, recovered, irq}, 0);

      // R2, R3, R4, R5: mode 00 with broken and spread-out runs
      enter(2'b00);
      chk(busoff == 1 && standby == 0, "R2", "busoff after entry", busoff, 1);
      strobes(10, 1, 0);
      strobes(1, 0, 0);           // R3: dominant restarts run only
      strobes(22, 1, 1);          // R4: two runs, idle dominant cycles ignored
      strobes(5, 1, 0);
      strobes(1, 0, 0);
      strobes(125 * 11, 1, 0);
      strobes(10, 1, 0);
      chk(busoff == 1 && recovered == 0, "R3", "still in bus-off one bit short", busoff, 1);
      strobes(1, 1, 0);
      chk(busoff == 0 && recovered == 1, "R5", "recovery after 128 runs", recovered, 1);
      chk(standby == 0, "R5", "no standby in automatic mode", standby, 0);

      // R7, R6
      irq_en = 1; idle(1);
      chk(irq == 1, "R7", "irq enabled", irq, 1);
      irq_en = 0; idle(1);
      chk(irq == 0, "R7", "irq masked", irq, 0);
      idle(5);
      chk(recovered == 1, "R6", "flag sticky", recovered, 1);
      clear_flag();
      chk(recovered == 0, "R6", "flag cleared", recovered, 0);

      // R8: channel reset mid-recovery
      enter(2'b00);
      strobes(40 * 11, 1, 0);
      request(2'b01);
      chk(busoff == 0 && standby == 0 && recovered == 0, "R8", "reset exit",
          {busoff, recovered}, 0);
      strobes(200, 1, 0);
      chk(recovered == 0, "R8", "no flag after reset exit", recovered, 0);

      // R9: forced recovery
      enter(2'b11);
      strobes(127 * 11 + 5, 1, 0);
      force_recover = 1; @(negedge clk); force_recover = 0;
      chk(busoff == 0 && recovered == 0, "R9", "forced exit", {busoff, recovered}, 0);
      strobes(20, 1, 0);
      chk(recovered == 0, "R9", "no flag after forced exit", recovered, 0);

      // R10: standby on entry
      enter(2'b01);
      chk(standby == 1 && busoff == 0, "R10", "standby at entry", {busoff, standby}, 1);
      strobes(128 * 11, 1, 0);
      chk(recovered == 0, "R10", "no flag in entry-standby mode", recovered, 0);
      request(2'b00);
      chk(standby == 0, "R13", "operate clears standby", standby, 0);

      // R11: standby request ignored in mode 00, honoured in mode 11
      enter(2'b00);
      strobes(3 * 11, 1, 0);
      request(2'b10);
      chk(busoff == 1 && standby == 0, "R11", "standby request ignored in mode 00",
          {busoff, standby}, 2);
      enter(2'b11);
      strobes(60 * 11, 1, 0);
      request(2'b10);
      chk(busoff == 0 && standby == 1 && recovered == 0, "R11", "standby on request",
          {busoff, standby, recovered}, 2);
      request(2'b01);
      chk(standby == 0, "R13", "reset request clears standby", standby, 0);

      // R12: standby at completion
      enter(2'b10);
      strobes(128 * 11, 1, 0);
      chk(recovered == 1 && standby == 1 && busoff == 0, "R12", "standby at end",
          {busoff, standby, recovered}, 3);
      clear_flag();
      request(2'b00);

      // R14: re-entry restarts the count
      enter(2'b00);
      strobes(100 * 11, 1, 0);
      enter(2'b00);
      strobes(127 * 11 + 10, 1, 0);
      chk(busoff == 1 && recovered == 0, "R14", "restart needs a full count", busoff, 1);
      strobes(1, 1, 0);
      chk(busoff == 0 && recovered == 1, "R14", "recovery after restart", recovered, 1);

      idle(4);
      summary();
   end
endmodule